// File: doc/BRIEF.md
# Rewindable Synchronous FIFO with Programmable Status Flags

This block is a single-clock first-in first-out buffer of parameterised depth and word width. One port writes words and another reads them. Read data is registered. Five active-low status outputs report the occupancy: empty, almost-empty, half-full, almost-full and full. Two of these outputs compare the word count against offsets that can be reloaded at run time.

A rewind input moves the read pointer back to physical address zero. A packet that has already been read can then be read again in the order it was written. Words written after the rewind follow the re-read data. Neither port acts during the rewind cycle or the cycle after it. The rewind is valid only when no more words than the depth have been written since reset and at least one word has been read since reset.

Top module: `rt_fifo`

## Requirements
- R1: An accepted read presents the oldest stored word on `rd_data` one clock edge after `rd_en` is sampled, and words leave in the order they were written.
- R2: `empty_n` is 0 exactly when the FIFO holds 0 words.
- R3: `aempty_n` is 0 while the word count is less than or equal to the low offset (reset value AE_DEF = 2).
- R4: `half_n` is 0 while the word count is greater than DEPTH/2 (8 at the default DEPTH of 16).
- R5: `afull_n` is 0 while the word count is at least DEPTH minus the high offset (reset value AF_DEF = 2).
- R6: `full_n` is 0 exactly when the FIFO holds DEPTH words. A write while full is ignored and stored data is not overwritten.
- R7: A read while empty is ignored. `rd_data` holds its value and the count stays 0.
- R8: A high `rewind` sets the read pointer to physical address 0. At the next edge the count equals the number of words written since reset, and the flags follow that count.
- R9: `wr_en` and `rd_en` have no effect in the cycle where `rewind` is sampled high or in the cycle after it.
- R10: After a rewind, reads return the earlier words again starting at address 0, followed by any words written after the rewind.
- R11: The first `ld_en` strobe after reset loads `ld_val` into the low offset. The next strobe loads the high offset, and further strobes keep alternating. Reset restores AE_DEF, AF_DEF and the alternation.
- R12: After reset all storage is empty: `empty_n`=0, `aempty_n`=0, `half_n`=1, `afull_n`=1, `full_n`=1 and `rd_data`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write request |
| wr_data | input | WIDTH | Word to store |
| rd_en | input | 1 | Read request |
| rd_data | output | WIDTH | Registered read word |
| rewind | input | 1 | Rewind the read pointer to address 0 |
| ld_en | input | 1 | Offset load strobe |
| ld_val | input | $clog2(DEPTH)-1 | Offset value to load |
| empty_n | output | 1 | Empty, active low |
| aempty_n | output | 1 | Almost-empty, active low |
| half_n | output | 1 | More than half full, active low |
| afull_n | output | 1 | Almost-full, active low |
| full_n | output | 1 | Full, active low |

## Verification
Every flag is decoded from the registered word count. A flag therefore changes at the same edge that samples the write or read causing the change. The read word appears at that same edge, one cycle after `rd_en` is sampled. A rewind changes the count and the flags at the edge that samples `rewind`, and the port lockout covers exactly the following cycle. The bench drives every input 2 ns after a rising edge and samples every output 2 ns after the next rising edge. Each expected value is therefore compared one edge after the stimulus that produces it.

// File: rtl/rt_fifo.sv
module rt_fifo #(
  parameter int WIDTH  = 8,
  parameter int DEPTH  = 16,
  parameter int AE_DEF = 2,
  parameter int AF_DEF = 2,
  localparam int AW = $clog2(DEPTH),
  localparam int OW = AW - 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rd_data,
  input  logic             rewind,
  input  logic             ld_en,
  input  logic [OW-1:0]    ld_val,
  output logic             empty_n,
  output logic             aempty_n,
  output logic             half_n,
  output logic             afull_n,
  output logic             full_n
);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW:0]      wp, rp, count;
  logic             hold_d;
  logic [OW-1:0]    lo_off, hi_off;
  logic             ld_sel;

  wire blocked = rewind | hold_d;
  wire do_wr   = wr_en & ~blocked & (count != (AW+1)'(DEPTH));
  wire do_rd   = rd_en & ~blocked & (count != '0);

  always_ff @(posedge clk) begin
    if (do_wr) mem[wp[AW-1:0]] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp      <= '0;
      rp      <= '0;
      count   <= '0;
      hold_d  <= 1'b0;
      rd_data <= '0;
    end else begin
      hold_d <= rewind;
      if (rewind) begin
        rp    <= '0;
        count <= wp;
      end else begin
        if (do_wr) wp <= wp + 1'b1;
        if (do_rd) begin
          rp      <= rp + 1'b1;
          rd_data <= mem[rp[AW-1:0]];
        end
        count <= count + (AW+1)'(do_wr) - (AW+1)'(do_rd);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_off <= OW'(AE_DEF);
      hi_off <= OW'(AF_DEF);
      ld_sel <= 1'b0;
    end else if (ld_en) begin
      if (ld_sel) hi_off <= ld_val;
      else        lo_off <= ld_val;
      ld_sel <= ~ld_sel;
    end
  end

  assign empty_n  = count != '0;
  assign aempty_n = ~(count <= (AW+1)'(lo_off));
  assign half_n   = ~(count > (AW+1)'(DEPTH/2));
  assign afull_n  = ~(count >= (AW+1)'(DEPTH) - (AW+1)'(hi_off));
  assign full_n   = count != (AW+1)'(DEPTH);

  p_count_bound_r6: assert property (@(posedge clk) disable iff (rst)
    count <= (AW+1)'(DEPTH));

  p_full_write_ignored_r6: assert property (@(posedge clk) disable iff (rst)
    (!full_n && wr_en && !rd_en && !rewind) |=> $stable(wp) && $stable(count));

  p_empty_read_ignored_r7: assert property (@(posedge clk) disable iff (rst)
    (!empty_n && rd_en && !wr_en && !rewind) |=> $stable(rd_data) && $stable(rp));

  p_rewind_zero_r8: assert property (@(posedge clk) disable iff (rst)
    rewind |=> (rp == '0));

  p_recovery_lock_r9: assert property (@(posedge clk) disable iff (rst)
    (hold_d && !rewind) |=> $stable(wp) && $stable(rp) && $stable(count));

  p_flag_nesting_r3: assert property (@(posedge clk) disable iff (rst)
    !empty_n |-> !aempty_n);

  p_full_implies_afull_r5: assert property (@(posedge clk) disable iff (rst)
    !full_n |-> !afull_n);

endmodule

// File: tb/rt_fifo_tb.sv
module rt_fifo_tb;
  localparam int W = 8;
  localparam int D = 16;

  logic clk = 1'b0, rst = 1'b1;
  logic wr_en = 0, rd_en = 0, rewind = 0, ld_en = 0;
  logic [W-1:0] wr_data = '0;
  logic [2:0] ld_val = '0;
  logic [W-1:0] rd_data;
  logic empty_n, aempty_n, half_n, afull_n, full_n;

  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  rt_fifo #(.WIDTH(W), .DEPTH(D), .AE_DEF(2), .AF_DEF(2)) u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
    .rd_data(rd_data), .rewind(rewind), .ld_en(ld_en), .ld_val(ld_val),
    .empty_n(empty_n), .aempty_n(aempty_n), .half_n(half_n),
    .afull_n(afull_n), .full_n(full_n));

  // fields: wr, rd, din[7:0], count[4:0], expected read word[7:0]
  localparam logic [22:0] VEC [8] = '{
    {1'b1, 1'b0, 8'h10, 5'd1, 8'h00},
    {1'b1, 1'b0, 8'h11, 5'd2, 8'h00},
    {1'b1, 1'b0, 8'h12, 5'd3, 8'h00},
    {1'b1, 1'b1, 8'h13, 5'd3, 8'h10},
    {1'b0, 1'b1, 8'h00, 5'd2, 8'h11},
    {1'b1, 1'b0, 8'h15, 5'd3, 8'h11},
    {1'b0, 1'b1, 8'h00, 5'd2, 8'h12},
    {1'b0, 1'b1, 8'h00, 5'd1, 8'h13}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_flags(input string tag, input int k, input int lo, input int hi);
    logic [4:0] e;
    e = {1'(k != 0), 1'(!(k <= lo)), 1'(!(k > D/2)), 1'(!(k >= D - hi)), 1'(k != D)};
    chk(tag, {27'd0, empty_n, aempty_n, half_n, afull_n, full_n}, {27'd0, e});
  endtask

  task automatic step(input logic w, input logic r, input logic [W-1:0] d,
                      input logic rt = 1'b0, input logic ld = 1'b0,
                      input logic [2:0] lv = 3'd0);
    wr_en = w; rd_en = r; wr_data = d; rewind = rt; ld_en = ld; ld_val = lv;
    @(posedge clk); #2;
    wr_en = 0; rd_en = 0; rewind = 0; ld_en = 0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    @(posedge clk); #2;
    @(posedge clk); #2;
    rst = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    // R12: reset state
    chk_flags("R12 reset flags", 0, 2, 2);
    chk("R12 reset rd_data", rd_data, 0);

    // table walk: R1 ordering and latency, R2..R5 flag decode
    for (int i = 0; i < 8; i++) begin
      step(VEC[i][22], VEC[i][21], VEC[i][20:13]);
      chk_flags("R2 R3 R4 R5 table flags", int'(VEC[i][12:8]), 2, 2);
      if (VEC[i][21]) chk("R1 table read word", rd_data, VEC[i][7:0]);
    end

    // R7: read while empty ignored
    do_reset();
    step(1'b0, 1'b1, 8'h00);
    chk("R7 empty read holds rd_data", rd_data, 0);
    chk_flags("R7 empty read flags", 0, 2, 2);

    // R6 R4 R5: fill to full, flags at each level
    for (int k = 1; k <= D; k++) begin
      step(1'b1, 1'b0, W'(k - 1));
      chk_flags("R4 R5 R6 fill flags", k, 2, 2);
    end
    step(1'b1, 1'b0, 8'hEE);
    chk_flags("R6 write while full flags", D, 2, 2);

    // R1 R6: drain, data intact
    for (int k = 0; k < D; k++) begin
      step(1'b0, 1'b1, 8'h00);
      chk("R6 drain word not overwritten", rd_data, k);
      chk_flags("R2 R3 drain flags", D - 1 - k, 2, 2);
    end

    // R8: rewind restores count of writes since reset
    step(1'b0, 1'b0, 8'h00, 1'b1);
    chk_flags("R8 flags after rewind", D, 2, 2);
    // R9: read in recovery cycle ignored
    step(1'b0, 1'b1, 8'h00);
    chk("R9 recovery read ignored rd_data", rd_data, 15);
    chk_flags("R9 recovery read ignored flags", D, 2, 2);

    // R10: re-read from address 0, then new data
    for (int k = 0; k < 3; k++) begin
      step(1'b0, 1'b1, 8'h00);
      chk("R10 reread word", rd_data, k);
    end
    step(1'b1, 1'b0, 8'h80);
    chk_flags("R10 write after rewind flags", 14, 2, 2);
    for (int k = 3; k < D; k++) begin
      step(1'b0, 1'b1, 8'h00);
      chk("R10 reread tail", rd_data, k);
    end
    step(1'b0, 1'b1, 8'h00);
    chk("R10 post-rewind word delivered", rd_data, 8'h80);
    chk_flags("R10 empty after all", 0, 2, 2);

    // R9: write during rewind cycle ignored
    do_reset();
    step(1'b1, 1'b0, 8'h01);
    step(1'b0, 1'b1, 8'h00);
    step(1'b1, 1'b0, 8'h55, 1'b1);
    chk_flags("R9 write during rewind ignored", 1, 2, 2);

    // R11: offset loading order
    do_reset();
    step(1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 3'd5);
    step(1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 3'd6);
    for (int k = 1; k <= 10; k++) begin
      step(1'b1, 1'b0, W'(k));
      if (k == 5 || k == 6 || k == 9 || k == 10)
        chk_flags("R11 loaded offsets", k, 5, 6);
    end
    do_reset();
    for (int k = 1; k <= 3; k++) step(1'b1, 1'b0, W'(k));
    chk_flags("R11 defaults after reset", 3, 2, 2);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule